// File: doc/BRIEF.md
# Mode-Selectable Serial Shift Register

This block holds one byte for a peripheral's serial port and moves it to or from an external serial engine once a countdown of clock-enable steps runs out. A three-bit mode, taken from bits 4:2 of an auxiliary control byte, decides what happens when the countdown ends. In the system-clock input mode, the block captures a byte from the external interface and raises a completion flag. In the free-running output mode, it presents its byte on an output strobe and reloads the countdown from the timer 2 low latch value plus two. The disabled mode and every other code do nothing with the data when the countdown ends.

The host reaches the data byte through a write strobe and a read strobe. Either access arms an eight-step countdown when the mode is nonzero, and either access clears the completion flag. The flag goes to the peripheral's interrupt logic, which can also clear it. A sticky indication reports that the countdown ended while an unsupported mode code was selected.

Top module: `shift_unit`

## Requirements
- R1: After reset the data byte reads 0x00, the mode is 0, the countdown is stopped, and flag_o, unsup_o, ser_stb_o and ser_byte_o are all low.
- R2: A control write stores bits 4:2 of wdata_i as the mode, with codes 0 = disabled, 2 = input under the system clock and 4 = free-running output. The other bits of the control byte have no effect.
- R3: A data write stores wdata_i so that rdata_o shows it after the next edge, and it clears flag_o. If the mode is nonzero, the write also arms the countdown to 8. In mode 0 the write does not arm the countdown.
- R4: A data read clears flag_o. If the mode is nonzero, the read also re-arms the countdown to 8.
- R5: The countdown drops by one on each clock edge where ce_i is high and the count is nonzero. It ends on the 8th enabled edge after arming, and edges with ce_i low do not count.
- R6: When the countdown ends in mode 2, the data byte takes ser_byte_i, flag_o goes high and the countdown stops. Later edges change neither the data byte nor the flag.
- R7: When the countdown ends in mode 4, ser_byte_o takes the data byte and ser_stb_o is high for exactly one cycle. The countdown reloads to t2_lo_i + 2, flag_o stays low and the data byte is kept.
- R8: When the countdown ends in mode 0, the countdown stops and flag_o is cleared. The data byte, ser_stb_o and unsup_o do not change.
- R9: When the countdown ends in mode 1, 3, 5, 6 or 7, the countdown stops, flag_o is cleared, the data byte is kept and unsup_o is set. unsup_o stays high until reset.
- R10: A data access on the same edge as an enabled step takes precedence. That step is dropped, so nothing ends on that edge.
- R11: flag_clr_i clears flag_o. If it arrives on the same edge that the countdown ends in mode 2, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Step enable for the countdown |
| ctl_wr_i | input | 1 | Control byte write strobe |
| dat_wr_i | input | 1 | Data byte write strobe |
| dat_rd_i | input | 1 | Data byte read strobe |
| wdata_i | input | 8 | Write data for the control and data bytes |
| rdata_o | output | 8 | Current data byte |
| t2_lo_i | input | 8 | Timer 2 low latch value, used as the output-mode interval |
| ser_byte_i | input | 8 | Byte from the external serial engine |
| ser_byte_o | output | 8 | Byte presented to the external serial engine |
| ser_stb_o | output | 1 | One-cycle strobe that marks a new ser_byte_o |
| flag_clr_i | input | 1 | Flag clear from the interrupt logic |
| flag_o | output | 1 | Completion flag |
| unsup_o | output | 1 | Sticky indication that the countdown ended in an unsupported mode |

## Verification
A countdown that is off by one step shows up at the first expiry after arming: the flag or the strobe appears one enabled cycle early or late. A wrong reload value in output mode shows up at the second strobe, as an interval other than t2_lo_i + 2. That is why the bench sweeps all 256 latch values, and all 256 capture bytes in input mode. If the block misdecodes the mode, the flag is raised, or unsup_o is set, on the first expiry after the mode write.

// File: rtl/su_pkg.sv
package su_pkg;
  localparam int unsigned SU_MODE_W = 3;
  localparam logic [SU_MODE_W-1:0] SU_MODE_OFF  = 3'd0;
  localparam logic [SU_MODE_W-1:0] SU_MODE_IN   = 3'd2;
  localparam logic [SU_MODE_W-1:0] SU_MODE_OUT  = 3'd4;

  typedef enum logic [1:0] {
    SU_ACT_HALT    = 2'd0,
    SU_ACT_CAPTURE = 2'd1,
    SU_ACT_EMIT    = 2'd2,
    SU_ACT_UNSUP   = 2'd3
  } su_act_e;
endpackage

// File: rtl/su_mode_dec.sv
module su_mode_dec
  import su_pkg::*;
(
  input  logic [SU_MODE_W-1:0] mode_i,
  output su_act_e              act_o,
  output logic                 armable_o
);
  always_comb begin
    unique case (mode_i)
      SU_MODE_OFF: act_o = SU_ACT_HALT;
      SU_MODE_IN:  act_o = SU_ACT_CAPTURE;
      SU_MODE_OUT: act_o = SU_ACT_EMIT;
      default:     act_o = SU_ACT_UNSUP;
    endcase
  end

  assign armable_o = (mode_i != SU_MODE_OFF);
endmodule

// File: rtl/su_step_ctr.sv
module su_step_ctr #(
  parameter int unsigned CW    = 9,
  parameter int unsigned STEPS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          hold_i,   // host access this cycle; step dropped
  input  logic          arm_i,
  input  logic          emit_i,   // reload on expiry instead of stopping
  input  logic [CW-1:0] reload_i,
  output logic          expire_o
);
  localparam logic [CW-1:0] ARM_VAL = CW'(STEPS);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [CW-1:0] cnt_q;

  assign expire_o = ce_i && !hold_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (arm_i) begin
      cnt_q <= ARM_VAL;
    end else if (!hold_i && ce_i && cnt_q != '0) begin
      if (cnt_q == ONE) cnt_q <= emit_i ? reload_i : '0;
      else              cnt_q <= cnt_q - ONE;
    end
  end

  a_r3_arm_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> cnt_q == ARM_VAL);

  a_r5_dec_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !hold_i && !arm_i && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);

  a_r10_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !arm_i) |=> $stable(cnt_q));
endmodule

// File: rtl/su_byte_path.sv
module su_byte_path
  import su_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          expire_i,
  input  su_act_e       act_i,
  input  logic [DW-1:0] ser_byte_i,
  input  logic          flag_clr_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] ser_byte_o,
  output logic          ser_stb_o,
  output logic          flag_o,
  output logic          unsup_o
);
  logic [DW-1:0] data_q, out_q;
  logic          stb_q, flag_q, unsup_q;
  logic          do_cap, do_emit, do_unsup;

  assign do_cap   = expire_i && (act_i == SU_ACT_CAPTURE);
  assign do_emit  = expire_i && (act_i == SU_ACT_EMIT);
  assign do_unsup = expire_i && (act_i == SU_ACT_UNSUP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      out_q   <= '0;
      stb_q   <= 1'b0;
      flag_q  <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      if (wr_i)        data_q <= wdata_i;
      else if (do_cap) data_q <= ser_byte_i;

      if (do_emit) out_q <= data_q;
      stb_q <= do_emit;

      // set beats every clear source
      if (do_cap)                                   flag_q <= 1'b1;
      else if (wr_i || rd_i || flag_clr_i || expire_i) flag_q <= 1'b0;

      if (do_unsup) unsup_q <= 1'b1;
    end
  end

  assign data_o     = data_q;
  assign ser_byte_o = out_q;
  assign ser_stb_o  = stb_q;
  assign flag_o     = flag_q;
  assign unsup_o    = unsup_q;

  a_r7_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_stb_o |=> !ser_stb_o);

  a_r6_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(expire_i && act_i == SU_ACT_CAPTURE));

  a_r9_unsup_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |=> unsup_o);

  a_r7_emit_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_emit && !wr_i) |=> $stable(data_q));
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import su_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned STEPS  = 8,
  parameter int unsigned MODE_LO = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          ctl_wr_i,
  input  logic          dat_wr_i,
  input  logic          dat_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] t2_lo_i,
  input  logic [DW-1:0] ser_byte_i,
  output logic [DW-1:0] ser_byte_o,
  output logic          ser_stb_o,
  input  logic          flag_clr_i,
  output logic          flag_o,
  output logic          unsup_o
);
  localparam int unsigned CW = DW + 1;  // room for latch + 2
  localparam logic [CW-1:0] RELOAD_ADD = CW'(2);

  logic [SU_MODE_W-1:0] mode_q;
  su_act_e              act;
  logic                 armable, access, expire;
  logic [CW-1:0]        reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= SU_MODE_OFF;
    else if (ctl_wr_i) mode_q <= wdata_i[MODE_LO +: SU_MODE_W];
  end

  assign access = dat_wr_i || dat_rd_i;
  assign reload = CW'(t2_lo_i) + RELOAD_ADD;

  su_mode_dec u_dec (
    .mode_i    (mode_q),
    .act_o     (act),
    .armable_o (armable)
  );

  su_step_ctr #(.CW(CW), .STEPS(STEPS)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_i     (ce_i),
    .hold_i   (access),
    .arm_i    (access && armable),
    .emit_i   (act == SU_ACT_EMIT),
    .reload_i (reload),
    .expire_o (expire)
  );

  su_byte_path #(.DW(DW)) u_path (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (dat_wr_i),
    .rd_i       (dat_rd_i),
    .wdata_i    (wdata_i),
    .expire_i   (expire),
    .act_i      (act),
    .ser_byte_i (ser_byte_i),
    .flag_clr_i (flag_clr_i),
    .data_o     (rdata_o),
    .ser_byte_o (ser_byte_o),
    .ser_stb_o  (ser_stb_o),
    .flag_o     (flag_o),
    .unsup_o    (unsup_o)
  );

  a_r3_wr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_i |=> rdata_o == $past(wdata_i));

  a_r4_access_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access |=> !flag_o);

  a_r10_no_expire_on_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access |=> !ser_stb_o);
endmodule

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, ctl_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0, flag_clr = 1'b0;
  logic [7:0] wdata = '0, t2_lo = '0, ser_in = '0;
  logic [7:0] rdata, ser_out;
  logic       ser_stb, flag, unsup;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  shift_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .ctl_wr_i(ctl_wr),
    .dat_wr_i(dat_wr), .dat_rd_i(dat_rd), .wdata_i(wdata), .rdata_o(rdata),
    .t2_lo_i(t2_lo), .ser_byte_i(ser_in), .ser_byte_o(ser_out),
    .ser_stb_o(ser_stb), .flag_clr_i(flag_clr), .flag_o(flag), .unsup_o(unsup)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after posedge
  task automatic cyc(input logic c, input logic w, input logic r,
                     input logic cw, input logic fc, input logic [7:0] d);
    @(negedge clk);
    ce = c; dat_wr = w; dat_rd = r; ctl_wr = cw; flag_clr = fc; wdata = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    ce = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0; ctl_wr = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic set_mode(input int m);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE3 | 8'((m & 7) << 2));
  endtask

  task automatic cnt_flag(input int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      step(1); n++;
      if (flag) break;
    end
  endtask

  task automatic cnt_stb(input int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      step(1); n++;
      if (ser_stb) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    #1;
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 flag", flag, 0);
    chk("R1 unsup", unsup, 0);
    chk("R1 stb", ser_stb, 0);
    chk("R1 ser_out", ser_out, 0);

    // R3 load in mode 0; R8 nothing is armed in mode 0
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
    chk("R3 load", rdata, 8'h5A);
    ser_in = 8'hFF;
    step(20);
    chk("R8 no capture", rdata, 8'h5A);
    chk("R8 no flag", flag, 0);
    chk("R8 no stb", ser_stb, 0);

    // R2 mode from bits 4:2, R6 capture on 8th step
    set_mode(2);
    ser_in = 8'h3C;
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11);
    cnt_flag(20, n);
    chk("R6 steps to flag", n, 8);
    chk("R6 capture", rdata, 8'h3C);
    ser_in = 8'h77;
    step(20);
    chk("R6 stopped data", rdata, 8'h3C);
    chk("R6 stopped flag", flag, 1);

    // R4 read clears and re-arms
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R4 read clears", flag, 0);
    cnt_flag(20, n);
    chk("R4 rearm steps", n, 8);
    chk("R4 rearm capture", rdata, 8'h77);

    // R5 disabled edges do not count
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      if (flag) break;
      step(1); n++;
      if (flag) break;
    end
    chk("R5 enabled steps", n, 8);

    // R10 access on expiry edge drops the step
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02);
    step(7);
    chk("R10 pre", flag, 0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R10 dropped", flag, 0);
    cnt_flag(20, n);
    chk("R10 rearmed steps", n, 8);

    // R11 clear, and set beats clear
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R11 clear", flag, 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h03);
    step(7);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R11 set wins", flag, 1);

    // R6 sweep of capture bytes
    for (int v = 0; v < 256; v++) begin
      ser_in = 8'(v);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ~8'(v));
      step(8);
      chk("R6 sweep data", rdata, v);
      chk("R6 sweep flag", flag, 1);
    end

    // R7 sweep of output interval
    set_mode(4);
    for (int v = 0; v < 256; v++) begin
      t2_lo = 8'(v);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'(v) ^ 8'hA5);
      cnt_stb(20, n);
      chk("R7 first strobe", n, 8);
      chk("R7 out byte", ser_out, v ^ 8'hA5);
      chk("R7 flag low", flag, 0);
      cnt_stb(300, n);
      chk("R7 interval", n, v + 2);
      chk("R7 data kept", rdata, v ^ 8'hA5);
    end

    // R8 expiry in mode 0
    set_mode(2);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h42);
    step(3);
    set_mode(0);
    ser_in = 8'hFF;
    step(10);
    chk("R8 data", rdata, 8'h42);
    chk("R8 flag", flag, 0);
    chk("R8 stb", ser_stb, 0);
    chk("R8 unsup", unsup, 0);

    // R9 unsupported codes, sticky until reset
    for (int m = 1; m < 8; m++) begin
      if (m == 2 || m == 4) continue;
      do_reset();
      set_mode(m);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99);
      step(7);
      chk("R9 not yet", unsup, 0);
      step(1);
      chk("R9 unsup set", unsup, 1);
      chk("R9 flag", flag, 0);
      chk("R9 data", rdata, 8'h99);
      chk("R9 stb", ser_stb, 0);
      set_mode(2);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      step(8);
      chk("R9 sticky", unsup, 1);
      do_reset();
      #1;
      chk("R9 reset clears", unsup, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule